// File: doc/BRIEF.md
# Cascaded Two-Counter Time-Stamp Capture

This block forms one wide time-stamp counter out of two equal-width counters and latches its value when a capture event arrives. The low counter advances on every clock in which counting is enabled. When it rolls over from all ones to zero it emits a one-cycle carry pulse. That pulse goes through one register stage before it advances the high counter, so the high half always trails the low half by one clock.

A capture event takes the low half at once. The high half is taken either in the same clock or, when the realign bit is set, one clock later. In the delayed case the low half is held in a stage register for that clock. The realigned choice gives a consistent stamp even when the capture falls right on a low-counter rollover.

Accepted stamps go to a capture register backed by one buffer entry. A read takes the oldest stamp. A capture that finds both entries occupied is thrown away and sets a sticky error flag. Both the capture flag and the error flag can drive an interrupt output through an enable.

Top module: `cap32_capture_unit`

## Requirements
- R1: The low counter advances by one on each clock edge with `en` high, holds with `en` low, and wraps from all ones to zero. The rollover produces a carry event one cycle wide.
- R2: The high counter advances by one on the edge that follows the carry event, whatever the level of `en`, and holds at all other times.
- R3: With `dly_en` high, a capture event on edge e commits on edge e+1. The committed stamp is {high, low}, where the low half is the low count before edge e and the high half is the high count before edge e+1. The stamp equals the number of enabled edges before edge e, modulo 2^(2*CNT_W).
- R4: With `dly_en` low, the stamp commits on edge e itself using the high count before edge e. When the low half is zero just after a rollover, the stamp therefore reads 2^CNT_W below the true count.
- R5: A commit into an empty channel loads `cap_val` and sets `cap_if`. A commit while `cap_if` is set and `buf_valid` is clear stores the stamp in the buffer and sets `buf_valid`. `cap_val` does not change.
- R6: A read with `buf_valid` set moves the buffer into `cap_val`, clears `buf_valid` and leaves `cap_if` set. A read with only `cap_if` set clears `cap_if`. A read with `cap_if` clear changes nothing.
- R7: A commit while `cap_if` and `buf_valid` are both set, with no read on that edge, is discarded. `cap_val` and the buffer keep their contents, and `err_if` is set.
- R8: `err_if` stays set until an `err_clr` pulse. If a discard and `err_clr` fall on the same edge, `err_if` ends set.
- R9: `cap_irq` is high exactly when `cap_if` and `cap_ie` are both high. `err_irq` is high exactly when `err_if` and `err_ie` are both high.
- R10: After reset, both counters, `cap_val`, `cap_if`, `buf_valid` and `err_if` are zero.
- R11: A read and a commit on the same edge are handled read first, then commit. From a single held stamp, the new stamp lands in `cap_val`. From a full channel, the buffered stamp moves to `cap_val` and the new stamp enters the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Low counter count enable |
| cap_evt | input | 1 | Capture event pulse |
| dly_en | input | 1 | Realign the high-half capture by one clock |
| rd | input | 1 | Read strobe for the capture register |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| cap_ie | input | 1 | Capture interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| cap_val | output | 2*CNT_W | Oldest captured stamp |
| cap_if | output | 1 | Capture register holds an unread stamp |
| buf_valid | output | 1 | Buffer entry holds a stamp |
| err_if | output | 1 | Sticky overflow error flag |
| cap_irq | output | 1 | Capture interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The counter properties assume `CNT_W` is wide enough that the low counter never rolls over on two edges in a row. They also assume that a carry event pending in the pipeline always reaches the high counter. The reject and read properties reason about the internal commit pulse. They therefore take it for granted that `dly_en` is held steady from a capture event until its commit edge, so a delayed commit and a direct commit never merge. The stimulus changes `dly_en` only in the cycle it raises a capture and holds it afterwards. It also keeps `en` high around every capture whose expected stamp depends on the rollover position.

// File: rtl/cap32_pkg.sv
package cap32_pkg;

   // occupancy of the capture register and its single buffer entry
   typedef enum logic [1:0] {
      CH_EMPTY = 2'd0,
      CH_ONE   = 2'd1,
      CH_FULL  = 2'd2
   } ch_fill_t;

   // which capture path feeds the channel
   typedef enum logic {
      SRC_DIRECT  = 1'b0,
      SRC_ALIGNED = 1'b1
   } cap_src_t;

endpackage

// File: rtl/cap32_counter.sv
module cap32_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/cap32_pipe.sv
module cap32_pipe #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cap32_pipe: DEPTH must be at least 1");
   end

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/cap32_channel.sv
module cap32_channel
   import cap32_pkg::*;
#(
   parameter int SW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic [SW-1:0] stamp,
   input  logic          rd,
   input  logic          err_clr,
   output logic [SW-1:0] cap_val,
   output logic          cap_if,
   output logic          buf_valid,
   output logic          err_if
);

   ch_fill_t      fill_q, fill_d;
   logic [SW-1:0] reg_q, reg_d;
   logic [SW-1:0] buf_q, buf_d;
   logic          err_q, err_d;
   logic          reject;

   always_comb begin
      fill_d = fill_q;
      reg_d  = reg_q;
      buf_d  = buf_q;
      err_d  = err_q;
      reject = 1'b0;

      // read first
      if (rd) begin
         unique case (fill_q)
            CH_ONE:  fill_d = CH_EMPTY;
            CH_FULL: begin
               reg_d  = buf_q;
               fill_d = CH_ONE;
            end
            default: ;
         endcase
      end

      // then the new stamp, against the post-read occupancy
      if (commit) begin
         unique case (fill_d)
            CH_EMPTY: begin
               reg_d  = stamp;
               fill_d = CH_ONE;
            end
            CH_ONE: begin
               buf_d  = stamp;
               fill_d = CH_FULL;
            end
            default: reject = 1'b1;
         endcase
      end

      if (err_clr) err_d = 1'b0;
      if (reject)  err_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= CH_EMPTY;
         reg_q  <= '0;
         buf_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         fill_q <= fill_d;
         reg_q  <= reg_d;
         buf_q  <= buf_d;
         err_q  <= err_d;
      end
   end

   assign cap_val   = reg_q;
   assign cap_if    = (fill_q != CH_EMPTY);
   assign buf_valid = (fill_q == CH_FULL);
   assign err_if    = err_q;

endmodule

// File: rtl/cap32_capture_unit.sv
module cap32_capture_unit
   import cap32_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int SW   = 2 * CNT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          cap_evt,
   input  logic          dly_en,
   input  logic          rd,
   input  logic          err_clr,
   input  logic          cap_ie,
   input  logic          err_ie,
   output logic [SW-1:0] cap_val,
   output logic          cap_if,
   output logic          buf_valid,
   output logic          err_if,
   output logic          cap_irq,
   output logic          err_irq
);

   localparam int EVT_STAGES = 1;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("cap32_capture_unit: CNT_W must lie in 2..32");
   end

   logic [CNT_W-1:0] lo_cnt, hi_cnt, lo_stage;
   logic             lo_wrap, ovf_evt, cap_evt_d;
   logic             commit;
   logic [SW-1:0]    stamp;
   cap_src_t         src;

   // low half: counts enabled clocks
   cap32_counter #(.W(CNT_W)) u_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (en),
      .cnt   (lo_cnt)
   );

   assign lo_wrap = en && (lo_cnt == {CNT_W{1'b1}});

   // carry travels as a pipelined event
   cap32_pipe #(.W(1), .DEPTH(EVT_STAGES)) u_ovf_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lo_wrap),
      .q     (ovf_evt)
   );

   cap32_counter #(.W(CNT_W)) u_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ovf_evt),
      .cnt   (hi_cnt)
   );

   // delayed capture path holds the low half for the same latency
   cap32_pipe #(.W(CNT_W + 1), .DEPTH(EVT_STAGES)) u_cap_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cap_evt, lo_cnt}),
      .q     ({cap_evt_d, lo_stage})
   );

   assign src    = dly_en ? SRC_ALIGNED : SRC_DIRECT;
   assign commit = (src == SRC_ALIGNED) ? cap_evt_d : cap_evt;
   assign stamp  = (src == SRC_ALIGNED) ? {hi_cnt, lo_stage} : {hi_cnt, lo_cnt};

   cap32_channel #(.SW(SW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .stamp     (stamp),
      .rd        (rd),
      .err_clr   (err_clr),
      .cap_val   (cap_val),
      .cap_if    (cap_if),
      .buf_valid (buf_valid),
      .err_if    (err_if)
   );

   assign cap_irq = cap_if & cap_ie;
   assign err_irq = err_if & err_ie;

endmodule

// File: rtl/cap32_capture_unit_chk.sv
module cap32_capture_unit_chk #(
   parameter int CNT_W = 16,
   localparam int SW   = 2 * CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CNT_W-1:0] lo_cnt,
   input logic [CNT_W-1:0] hi_cnt,
   input logic             lo_wrap,
   input logic             ovf_evt,
   input logic             commit,
   input logic             rd,
   input logic             err_clr,
   input logic [SW-1:0]    cap_val,
   input logic             cap_if,
   input logic             buf_valid,
   input logic             err_if
);

   AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wrap |=> !lo_wrap); // R1

   AST_LO_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (en && lo_cnt == {CNT_W{1'b1}}) |=> (lo_cnt == '0)); // R1

   AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(lo_cnt)); // R1

   AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (hi_cnt == CNT_W'($past(hi_cnt) + 1'b1))); // R2

   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_evt |=> $stable(hi_cnt)); // R2

   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cap_if && buf_valid && !rd) |=> (err_if && $stable(cap_val) && buf_valid)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_if && !err_clr) |=> err_if); // R8

   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !cap_if && !commit) |=> (!cap_if && $stable(cap_val))); // R6

   AST_BUF_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && buf_valid && !commit) |=> (cap_if && !buf_valid)); // R6

endmodule

bind cap32_capture_unit cap32_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .lo_cnt    (lo_cnt),
   .hi_cnt    (hi_cnt),
   .lo_wrap   (lo_wrap),
   .ovf_evt   (ovf_evt),
   .commit    (commit),
   .rd        (rd),
   .err_clr   (err_clr),
   .cap_val   (cap_val),
   .cap_if    (cap_if),
   .buf_valid (buf_valid),
   .err_if    (err_if)
);

// File: tb/cap32_capture_unit_tb.sv
module cap32_capture_unit_tb;

   localparam int CW  = 8;
   localparam int SW  = 2 * CW;
   localparam int MOD = 1 << SW;
   localparam int LOM = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, cap_evt = 1'b0, dly_en = 1'b1, rd = 1'b0, err_clr = 1'b0;
   logic          cap_ie = 1'b0, err_ie = 1'b0;
   logic [SW-1:0] cap_val;
   logic          cap_if, buf_valid, err_if, cap_irq, err_irq;

   int  checks = 0;
   int  errors = 0;
   int  tb_t   = 0;
   bit  done   = 1'b0;

   // {dly, target low half}
   localparam logic [CW:0] VEC [10] = '{
      {1'b1, 8'hFF}, {1'b1, 8'h00}, {1'b1, 8'h01}, {1'b1, 8'h80},
      {1'b0, 8'h00}, {1'b0, 8'h01}, {1'b0, 8'hFF}, {1'b0, 8'h42},
      {1'b1, 8'h00}, {1'b0, 8'h00}
   };

   always #2 clk = ~clk;

   always @(posedge clk) if (rst_n && en) tb_t <= tb_t + 1;

   cap32_capture_unit #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cap_evt(cap_evt), .dly_en(dly_en),
      .rd(rd), .err_clr(err_clr), .cap_ie(cap_ie), .err_ie(err_ie),
      .cap_val(cap_val), .cap_if(cap_if), .buf_valid(buf_valid),
      .err_if(err_if), .cap_irq(cap_irq), .err_irq(err_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // expected stamp for a capture raised now
   function automatic int stamp_exp(input bit dly);
      int lo = tb_t % LOM;
      if (!dly && lo == 0 && tb_t != 0) return (tb_t - LOM) % MOD;
      return tb_t % MOD;
   endfunction

   task automatic capture(input bit dly, output int exp);
      dly_en  = dly;
      exp     = stamp_exp(dly);
      cap_evt = 1'b1;
      tick();
      cap_evt = 1'b0;
      if (dly) tick();
   endtask

   task automatic read_once();
      rd = 1'b1;
      tick();
      rd = 1'b0;
   endtask

   task automatic wait_lo(input int target);
      while ((tb_t % LOM) != target) tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int a, b, c, d, e;
      repeat (3) tick();
      // R10 reset state
      check("R10 cap_val", int'(cap_val), 0);
      check("R10 flags", {cap_if, buf_valid, err_if, cap_irq, err_irq}, 0);
      rst_n = 1'b1;
      en    = 1'b1;

      // vector walk: R3 / R4 / R2 stamp alignment at the rollover
      foreach (VEC[i]) begin
         int exp;
         string tag;
         wait_lo(int'(VEC[i][CW-1:0]));
         capture(VEC[i][CW], exp);
         if (VEC[i][CW]) tag = "R3 aligned stamp";
         else if (VEC[i][CW-1:0] == 0) tag = "R4 lagging stamp";
         else tag = "R2 high step timing";
         check(tag, int'(cap_val), exp);
         check("R5 cap_if after load", int'(cap_if), 1);
         read_once();
         check("R6 read clears cap_if", int'(cap_if), 0);
      end

      // R1 counting holds while disabled
      capture(1'b1, a);
      en = 1'b0;
      repeat (7) tick();
      en = 1'b1;
      capture(1'b1, b);
      check("R1 cap_val", int'(cap_val), a);
      read_once();
      check("R1 gated count", int'(cap_val), b);
      check("R1 gap", (b - a + MOD) % MOD, 2);
      read_once();

      // R5 fill then R7 reject
      capture(1'b1, a);
      capture(1'b1, b);
      check("R5 buffer keeps cap_val", int'(cap_val), a);
      check("R5 buf_valid", int'(buf_valid), 1);
      check("R8 no error yet", int'(err_if), 0);
      capture(1'b1, c);
      check("R7 err_if", int'(err_if), 1);
      check("R7 cap_val kept", int'(cap_val), a);
      // R9 interrupt gating
      check("R9 err_irq off", int'(err_irq), 0);
      err_ie = 1'b1;
      cap_ie = 1'b1;
      #0;
      check("R9 err_irq on", int'(err_irq), 1);
      check("R9 cap_irq on", int'(cap_irq), 1);
      read_once();
      check("R6 buffer moves", int'(cap_val), b);
      check("R6 buf_valid cleared", int'(buf_valid), 0);
      check("R6 cap_if kept", int'(cap_if), 1);
      read_once();
      check("R6 cap_if cleared", int'(cap_if), 0);
      check("R9 cap_irq follows", int'(cap_irq), 0);
      check("R7 discarded stamp", int'(cap_val), b);
      check("R8 sticky after reads", int'(err_if), 1);
      err_clr = 1'b1;
      tick();
      err_clr = 1'b0;
      check("R8 cleared", int'(err_if), 0);
      check("R9 err_irq cleared", int'(err_irq), 0);
      cap_ie = 1'b0;
      err_ie = 1'b0;

      // R6 idle read
      read_once();
      check("R6 idle read cap_if", int'(cap_if), 0);
      check("R6 idle read cap_val", int'(cap_val), b);

      // R11 read and commit together, single stamp held
      capture(1'b0, a);
      dly_en = 1'b0;
      d = stamp_exp(1'b0);
      rd = 1'b1;
      cap_evt = 1'b1;
      tick();
      rd = 1'b0;
      cap_evt = 1'b0;
      check("R11 new stamp loaded", int'(cap_val), d);
      check("R11 buffer empty", int'(buf_valid), 0);
      check("R11 cap_if", int'(cap_if), 1);

      // R11 from a full channel
      capture(1'b0, e);
      d = stamp_exp(1'b0);
      rd = 1'b1;
      cap_evt = 1'b1;
      tick();
      rd = 1'b0;
      cap_evt = 1'b0;
      check("R11 buffered moved up", int'(cap_val), e);
      check("R11 new stamp buffered", int'(buf_valid), 1);
      check("R11 no error", int'(err_if), 0);

      // R8 set wins over clear
      err_clr = 1'b1;
      cap_evt = 1'b1;
      tick();
      err_clr = 1'b0;
      cap_evt = 1'b0;
      check("R8 set wins", int'(err_if), 1);
      read_once();
      check("R11 second stamp", int'(cap_val), d);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule